// File: doc/BRIEF.md
# Dual-Mode Serial Shift Port

This block is an eight-bit synchronous serial port with three signals: a serial clock, a data input and a data output. Software loads a byte into the shift register through a small two-address register interface. It then starts a transfer by writing the control register with its start bit set. For eight clock pulses the loaded byte leaves most significant bit first while an incoming byte enters behind it. When the transfer ends, the received byte is read back from the same address.

The port can work as clock master or as clock slave. As master, it divides the system clock to make the serial clock, with a half period of 2, 4 or 8 system cycles. The clock runs only while a transfer is in progress, and it returns low after the eighth pulse. As slave, it takes the serial clock from outside, passes it and the data input through a two-stage synchroniser, and detects its edges; the system clock must be at least four times the serial clock.

The data output can be driven or tri-stated through an output-enable pin. A phase control chooses which clock edge advances the register. In normal phase the register advances on the falling edge. In alternate phase it advances on the rising edge. Clearing the enable bit releases both pad enables.

Top module: `serial_shift_port`

## Requirements
- R1: After reset the control register reads 0 (disabled, slave, output tri-stated, normal phase, half period 2), the data register reads 0, and ser_clk_out, ser_clk_oe, ser_out_oe and xfer_done are all low.
- R2: A write to address 1 whose bit 1 (start) and bit 0 (enable) are both 1 sets the busy flag, which reads back as bit 1 of address 1. A start written with bit 0 at 0 leaves busy clear, and no clock pulse or done pulse follows.
- R3: With control bit 2 (clock master) at 1, ser_clk_out makes exactly eight pulses. Each half of a pulse lasts H system cycles, where H is 2, 4 or 8 for control bits 6:5 equal to 0, 1 or 2 or more. The first rise comes H cycles after the starting write is clocked, and the clock stays low at all other times.
- R4: After the eighth falling edge, busy clears and xfer_done is high for exactly one system cycle. In master mode this is 16·H+1 cycles after the starting write. In slave mode it is the third system cycle after the falling edge at the pin.
- R5: Data goes out most significant bit first: when pulse i rises (i = 0..7), ser_out holds bit 7−i of the loaded byte.
- R6: Once the transfer is done, address 0 returns the eight ser_in values sampled at the rising edges, first sample in bit 7, in both phase modes.
- R7: With control bit 4 at 0 (normal phase), ser_out changes only after falling edges, so it is steady while the clock is high. With bit 4 at 1 (alternate phase), the register advances on rising edges, so ser_out is steady while the clock is low.
- R8: With control bit 2 at 0 (slave), ser_clk_oe is low, ser_clk_out stays low, and a transfer is timed by the synchronised ser_clk_in.
- R9: ser_clk_oe equals enable AND clock master. ser_out_oe equals enable AND control bit 3 (drive output).
- R10: While busy, writes to either address have no effect on the shift register, the control fields or the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = shift register, 1 = control register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register |
| ser_in | input | 1 | Serial data input |
| ser_clk_in | input | 1 | External serial clock (slave mode) |
| ser_out | output | 1 | Serial data output |
| ser_out_oe | output | 1 | Output enable for ser_out |
| ser_clk_out | output | 1 | Generated serial clock (master mode) |
| ser_clk_oe | output | 1 | Output enable for ser_clk_out |
| xfer_done | output | 1 | One-cycle pulse when a transfer ends |

## Verification
Each internal state shows up at the pins in its own way. A bit counter that is off by one moves xfer_done and the fall of busy by one full serial period, 2·H system cycles, so the per-cycle comparison against the reference timeline catches it on the last pulse. A shift register or phase-select fault shows on ser_out at the next rising edge, within one serial period of the fault, or as a change in the half of the clock that should be steady. A fault in the capture path or in input synchronisation stays hidden until the byte is read back after xfer_done, which is why every transfer uses a received pattern that differs from the transmitted one.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    localparam int unsigned DATA_W   = 8;
    localparam int unsigned HP_W     = 4;
    localparam int unsigned SYNC_N   = 2;

    // control register bit positions
    localparam int unsigned CB_EN    = 0;
    localparam int unsigned CB_GO    = 1;
    localparam int unsigned CB_MST   = 2;
    localparam int unsigned CB_DRV   = 3;
    localparam int unsigned CB_ALT   = 4;
    localparam int unsigned CB_DIV   = 5;

    typedef enum logic {
        ADDR_DATA = 1'b0,
        ADDR_CTRL = 1'b1
    } reg_addr_e;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       alt_phase;
        logic       drive_out;
        logic       clk_master;
        logic       enable;
    } ctrl_t;

    // system cycles per half of a generated serial clock period
    function automatic logic [HP_W-1:0] half_period(input logic [1:0] sel);
        case (sel)
            2'd0:    return HP_W'(2);
            2'd1:    return HP_W'(4);
            default: return HP_W'(8);
        endcase
    endfunction

endpackage

// File: rtl/ssp_sync.sv
module ssp_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ssp_sclk_gen.sv
module ssp_sclk_gen #(
    parameter int unsigned HP_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [HP_W-1:0] half_cycles,
    output logic            sclk
);
    localparam logic [HP_W-1:0] ONE = HP_W'(1);

    logic [HP_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            sclk  <= 1'b0;
        end else if (cnt_q == half_cycles - ONE) begin
            cnt_q <= '0;
            sclk  <= ~sclk;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/ssp_shift_core.sv
module ssp_shift_core #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              start,
    input  logic              alt_phase,
    input  logic              rise,
    input  logic              fall,
    input  logic              din,
    output logic [DATA_W-1:0] shreg,
    output logic              busy,
    output logic              done,
    output logic              shift_evt
);
    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] bit_cnt_q;
    logic             cap_q;
    logic             shift_bit;

    assign shift_evt = busy && (alt_phase ? rise : fall);
    assign shift_bit = alt_phase ? din : cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg     <= '0;
            cap_q     <= 1'b0;
            bit_cnt_q <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (load)  shreg <= load_data;
                if (start) begin
                    busy      <= 1'b1;
                    bit_cnt_q <= '0;
                end
            end else begin
                if (rise && !alt_phase) cap_q <= din;
                if (shift_evt) shreg <= {shreg[DATA_W-2:0], shift_bit};
                if (fall) begin
                    if (bit_cnt_q == LAST) begin
                        busy      <= 1'b0;
                        done      <= 1'b1;
                        bit_cnt_q <= '0;
                    end else begin
                        bit_cnt_q <= bit_cnt_q + ONE;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/serial_shift_port.sv
module serial_shift_port
    import ssp_pkg::*;
#(
    parameter int unsigned DATA_W      = ssp_pkg::DATA_W,
    parameter int unsigned SYNC_STAGES = ssp_pkg::SYNC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              ser_in,
    input  logic              ser_clk_in,
    output logic              ser_out,
    output logic              ser_out_oe,
    output logic              ser_clk_out,
    output logic              ser_clk_oe,
    output logic              xfer_done
);
    ctrl_t             ctrl_q;
    logic              busy_w;
    logic              shift_evt_w;
    logic [DATA_W-1:0] shreg_w;
    logic              ctrl_wr_w;
    logic              data_wr_w;
    logic              start_w;
    logic              din_s;
    logic              sclk_s;
    logic              sclk_int;
    logic              clk_eff;
    logic              clk_prev_q;
    logic              rise_w;
    logic              fall_w;
    logic [7:0]        ctrl_rd;

    assign ctrl_wr_w = reg_wr && (reg_addr == ADDR_CTRL) && !busy_w;
    assign data_wr_w = reg_wr && (reg_addr == ADDR_DATA) && !busy_w;
    assign start_w   = ctrl_wr_w && reg_wdata[CB_GO] && reg_wdata[CB_EN];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr_w) begin
            ctrl_q.enable     <= reg_wdata[CB_EN];
            ctrl_q.clk_master <= reg_wdata[CB_MST];
            ctrl_q.drive_out  <= reg_wdata[CB_DRV];
            ctrl_q.alt_phase  <= reg_wdata[CB_ALT];
            ctrl_q.div_sel    <= reg_wdata[CB_DIV+1:CB_DIV];
        end
    end

    ssp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ser_in, ser_clk_in}),
        .q   ({din_s, sclk_s})
    );

    ssp_sclk_gen #(.HP_W(HP_W)) u_sclk_gen (
        .clk         (clk),
        .rst         (rst),
        .run         (busy_w && ctrl_q.clk_master),
        .half_cycles (half_period(ctrl_q.div_sel)),
        .sclk        (sclk_int)
    );

    // one edge detector serves both clock sources
    assign clk_eff = ctrl_q.clk_master ? sclk_int : sclk_s;

    always_ff @(posedge clk) begin
        if (rst) clk_prev_q <= 1'b0;
        else     clk_prev_q <= clk_eff;
    end

    assign rise_w = busy_w &&  clk_eff && !clk_prev_q;
    assign fall_w = busy_w && !clk_eff &&  clk_prev_q;

    ssp_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .load      (data_wr_w),
        .load_data (reg_wdata),
        .start     (start_w),
        .alt_phase (ctrl_q.alt_phase),
        .rise      (rise_w),
        .fall      (fall_w),
        .din       (din_s),
        .shreg     (shreg_w),
        .busy      (busy_w),
        .done      (xfer_done),
        .shift_evt (shift_evt_w)
    );

    assign ctrl_rd = {1'b0, ctrl_q.div_sel, ctrl_q.alt_phase, ctrl_q.drive_out,
                      ctrl_q.clk_master, busy_w, ctrl_q.enable};

    assign reg_rdata   = (reg_addr == ADDR_CTRL) ? DATA_W'(ctrl_rd) : shreg_w;
    assign ser_out     = shreg_w[DATA_W-1];
    assign ser_out_oe  = ctrl_q.enable && ctrl_q.drive_out;
    assign ser_clk_out = sclk_int;
    assign ser_clk_oe  = ctrl_q.enable && ctrl_q.clk_master;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctrl_wr,
    input logic              wd_en,
    input logic              wd_go,
    input logic              busy,
    input logic              done,
    input logic              sclk_out,
    input logic              sclk_oe,
    input logic              sdat_oe,
    input logic              en,
    input logic              mst,
    input logic              shift_evt,
    input logic [DATA_W-1:0] shreg
);
    assert_start_sets_busy_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wd_en && wd_go) |=> busy);

    assert_no_start_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wd_en && !busy) |=> !busy);

    assert_clk_low_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sclk_out);

    assert_done_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_means_idle_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_end_flags_done_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_slave_clk_released_R8: assert property (@(posedge clk) disable iff (rst)
        !mst |-> !sclk_oe);

    assert_pads_released_R9: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!sdat_oe && !sclk_oe));

    assert_write_ignored_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !shift_evt) |=> $stable(shreg));
endmodule

bind serial_shift_port ssp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr   (ctrl_wr_w),
    .wd_en     (reg_wdata[ssp_pkg::CB_EN]),
    .wd_go     (reg_wdata[ssp_pkg::CB_GO]),
    .busy      (busy_w),
    .done      (xfer_done),
    .sclk_out  (ser_clk_out),
    .sclk_oe   (ser_clk_oe),
    .sdat_oe   (ser_out_oe),
    .en        (ctrl_q.enable),
    .mst       (ctrl_q.clk_master),
    .shift_evt (shift_evt_w),
    .shreg     (shreg_w)
);

// File: tb/tb_serial_shift_port.sv
module tb_serial_shift_port;
    localparam int DW   = 8;
    localparam int MAXC = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic          reg_addr = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          ser_in = 1'b0;
    logic          ser_clk_in = 1'b0;
    logic          ser_out, ser_out_oe, ser_clk_out, ser_clk_oe, xfer_done;

    int checks = 0;
    int fails  = 0;

    // reference timeline for a master transfer
    bit m_active = 1'b0;
    int m_k      = 0;
    int m_H      = 2;
    bit m_drv    = 1'b0;

    always #4 clk = ~clk;

    serial_shift_port dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_in(ser_in), .ser_clk_in(ser_clk_in),
        .ser_out(ser_out), .ser_out_oe(ser_out_oe),
        .ser_clk_out(ser_clk_out), .ser_clk_oe(ser_clk_oe),
        .xfer_done(xfer_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        if (m_active) m_k = m_k + 1;
    end

    always @(negedge clk) begin : ref_compare
        bit es;
        bit ed;
        if (m_active && m_k >= 0) begin
            es = (m_k < 16 * m_H) && (((m_k / m_H) % 2) == 1);
            ed = (m_k == 16 * m_H + 1);
            check(ser_clk_out == es, "R3 master clock timeline", ser_clk_out, es);
            check(xfer_done == ed, "R4 done pulse timing", xfer_done, ed);
            check(ser_clk_oe == 1'b1, "R9 clock enable master", ser_clk_oe, 1);
            check(ser_out_oe == m_drv, "R9 data enable", ser_out_oe, m_drv);
        end
    end

    task automatic write_reg(input bit a, input logic [DW-1:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input bit a, output logic [DW-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
        @(negedge clk);
    endtask

    task automatic run_master(input logic [7:0] tx, input logic [7:0] rx,
                              input logic [1:0] div, input bit alt, input bit drv,
                              input bit inj);
        int h;
        int pulses;
        int inj_st;
        bit prev_clk;
        bit prev_out;
        logic [DW-1:0] v;
        h = (div == 2'd0) ? 2 : (div == 2'd1) ? 4 : 8;
        pulses = 0; inj_st = 0;
        write_reg(1'b0, tx);
        ser_in = rx[7];
        m_H = h; m_drv = drv; m_k = -1; m_active = 1'b1;
        reg_wr = 1'b1; reg_addr = 1'b1;
        reg_wdata = {1'b0, div, alt, drv, 1'b1, 1'b1, 1'b1};
        @(negedge clk);
        reg_wr = 1'b0;
        prev_clk = ser_clk_out; prev_out = ser_out;
        while (m_k < 16 * h + 2) begin
            if (ser_clk_out && !prev_clk) begin
                if (pulses < 8)
                    check(ser_out == tx[7 - pulses], "R5 msb-first bit at rise", ser_out, tx[7 - pulses]);
                pulses++;
            end
            if (!ser_clk_out && prev_clk && pulses < 8) ser_in = rx[7 - pulses];
            if (!alt && ser_clk_out && prev_clk)
                check(ser_out == prev_out, "R7 normal phase steady while high", ser_out, prev_out);
            if (alt && !ser_clk_out && !prev_clk)
                check(ser_out == prev_out, "R7 alternate phase steady while low", ser_out, prev_out);
            if (inj) begin
                case (inj_st)
                    0: if (pulses == 3) begin
                           reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'hFF; inj_st = 1;
                       end
                    1: begin reg_addr = 1'b1; reg_wdata = 8'h00; inj_st = 2; end
                    2: begin reg_wr = 1'b0; reg_addr = 1'b1; inj_st = 3; end
                    3: begin
                           check(reg_rdata[1] == 1'b1, "R2 busy reads back", reg_rdata[1], 1);
                           check(reg_rdata[0] == 1'b1, "R10 control write ignored", reg_rdata[0], 1);
                           inj_st = 4;
                       end
                    default: ;
                endcase
            end
            prev_clk = ser_clk_out; prev_out = ser_out;
            @(negedge clk);
        end
        m_active = 1'b0;
        check(pulses == 8, "R3 pulse count", pulses, 8);
        read_reg(1'b0, v);
        check(v == rx, inj ? "R6 received byte (R10 data write ignored)" : "R6 received byte", v, rx);
        read_reg(1'b1, v);
        check(v[1] == 1'b0, "R4 busy cleared", v[1], 0);
    endtask

    task automatic run_slave(input logic [7:0] tx, input logic [7:0] rx, input bit alt, input bit drv);
        logic [DW-1:0] v;
        write_reg(1'b0, tx);
        ser_in = rx[7]; ser_clk_in = 1'b0;
        write_reg(1'b1, {1'b0, 2'd0, alt, drv, 1'b0, 1'b1, 1'b1});
        repeat (3) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            check(ser_out == tx[7 - i], "R5 slave msb-first bit", ser_out, tx[7 - i]);
            check(ser_clk_oe == 1'b0 && ser_clk_out == 1'b0, "R8 slave clock pins idle",
                  {ser_clk_oe, ser_clk_out}, 0);
            check(ser_out_oe == drv, "R9 slave data enable", ser_out_oe, drv);
            ser_clk_in = 1'b1;
            repeat (5) @(negedge clk);
            ser_clk_in = 1'b0;
            if (i < 7) begin
                ser_in = rx[6 - i];
                repeat (5) @(negedge clk);
            end
        end
        @(negedge clk);
        check(xfer_done == 1'b0, "R4 slave done not early", xfer_done, 0);
        @(negedge clk);
        check(xfer_done == 1'b0, "R4 slave done not early", xfer_done, 0);
        @(negedge clk);
        check(xfer_done == 1'b1, "R4 slave done after three cycles", xfer_done, 1);
        @(negedge clk);
        check(xfer_done == 1'b0, "R4 slave done single cycle", xfer_done, 0);
        read_reg(1'b0, v);
        check(v == rx, "R6 R8 slave received byte", v, rx);
        read_reg(1'b1, v);
        check(v[1] == 1'b0, "R4 slave busy cleared", v[1], 0);
    endtask

    initial begin : watchdog
        repeat (MAXC) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin : main
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        read_reg(1'b1, v);
        check(v == 8'h00, "R1 control after reset", v, 0);
        read_reg(1'b0, v);
        check(v == 8'h00, "R1 data after reset", v, 0);
        check({ser_clk_out, ser_clk_oe, ser_out_oe, xfer_done} == 4'b0, "R1 outputs after reset",
              {ser_clk_out, ser_clk_oe, ser_out_oe, xfer_done}, 0);

        // R2 start without enable: nothing happens
        write_reg(1'b1, 8'b0000_0110);
        for (int i = 0; i < 40; i++) begin
            check({ser_clk_out, ser_clk_oe, ser_out_oe, xfer_done} == 4'b0,
                  "R2 R9 disabled port stays quiet",
                  {ser_clk_out, ser_clk_oe, ser_out_oe, xfer_done}, 0);
            @(negedge clk);
        end
        read_reg(1'b1, v);
        check(v == 8'h04, "R2 busy stays clear when disabled", v, 8'h04);

        // master transfers over every divide ratio and both phases
        run_master(8'hA5, 8'h3C, 2'd0, 1'b0, 1'b1, 1'b1);
        run_master(8'h96, 8'hC3, 2'd1, 1'b1, 1'b0, 1'b0);
        run_master(8'h01, 8'h80, 2'd2, 1'b0, 1'b1, 1'b0);
        run_master(8'h7E, 8'h5A, 2'd3, 1'b1, 1'b1, 1'b1);

        // slave transfers in both phases
        run_slave(8'h5A, 8'hE7, 1'b0, 1'b1);
        run_slave(8'h81, 8'h7E, 1'b1, 1'b0);

        report();
        $finish;
    end
endmodule